// File: doc/BRIEF.md
# Serial Tuning-Control Frame Receiver

This block takes control words for a frequency synthesizer over a three-wire serial link made of a data line, a bit clock and an enable strobe. While the enable line is high, each rising edge of the bit clock shifts one data bit into a shift register and advances a bit counter. When the enable line drops, the counter value picks one of three legal frame layouts: a short 18-bit frame, a standard 19-bit frame, or a 34-bit frame that also carries test and feature bits. Any other length is thrown away.

On a legal frame the block loads three registers that hold the band-buffer bits, the programmable divider ratio and the test bits. It also produces two derived signals: the reference-divider select, and the flag that routes the internal test frequencies to the two upper band outputs. A one-cycle strobe marks each load. The three bus inputs are assumed to be already synchronous to the system clock.

Top module: `tune_frame_rx`

## Requirements
- R1: After a synchronous active-low reset, band_q, div_q and test_q are all zero, ref_div_1024 is 0 (divide by 512), and test_route and frame_taken are 0.
- R2: In a 19-bit frame the first four bits shifted are band bits 3 down to 0 and go to band_q[3:0]. The remaining fifteen bits go to div_q[14:0], most significant first.
- R3: In an 18-bit frame the first four bits go to band_q[3:0] and the remaining fourteen go to div_q[13:0]. div_q[14] is loaded with 0.
- R4: In a 34-bit frame the bits are, in order, band_q[3:0], div_q[14:0] and test_q[6:0], followed by eight padding bits. The padding bits have no effect on any output.
- R5: An 18-bit or 19-bit frame loads test_q with zero. As a result ref_div_1024 returns to 0 and test_route to 0.
- R6: A frame of any length other than 18, 19 or 34 bit-clock rising edges, including zero, leaves every output unchanged and raises no frame_taken.
- R7: The outputs change only at the end of a legal frame. While enable is high they keep their previous values.
- R8: Bit-clock rising edges that arrive while enable is low are neither shifted nor counted.
- R9: frame_taken is high for exactly one cycle. That cycle is the one after the clock edge at which the low enable is first seen, and it is also when the new values appear on the outputs.
- R10: With the default build (FIXED_REF = 0), ref_div_1024 equals test_q[5]. With FIXED_REF = 1, it is 1 at all times.
- R11: test_route is 1 exactly when test_q[4], band_q[3] and band_q[2] are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_dat | input | 1 | Serial data, sampled on a bit-clock rising edge |
| bus_clk | input | 1 | Serial bit clock (synchronous to clk) |
| bus_en | input | 1 | Frame enable; high during a frame |
| band_q | output | BAND_W (4) | Band-buffer control bits |
| div_q | output | DIV_W (15) | Programmable divider ratio |
| test_q | output | TST_W (7) | Test and feature bits |
| ref_div_1024 | output | 1 | Reference divider select: 1 = divide by 1024, 0 = divide by 512 |
| test_route | output | 1 | Internal test frequencies routed to the two upper band outputs |
| frame_taken | output | 1 | One-cycle strobe when a legal frame is loaded |

## Verification
If the bit counter is off by one, legal frames are rejected and illegal ones accepted. This shows up at the first enable fall, either as a missing or extra frame_taken or as outputs that failed to change. If the shift register is misaligned, every field is displaced, which shows in band_q and div_q in the cycle of the strobe. A wrong choice of mapping per length shows only in the top divider bit or in test_q, so the bench sends 18-bit frames with bit 14 set by the previous frame, and short frames after test-bit frames. Stray shifting while enable is low is exposed by a legal frame that follows idle bit-clock activity.

// File: rtl/tune_pkg.sv
// Package tune_pkg
// Shared field widths, derived frame lengths, test-bit positions and the
// frame-kind encoding used by the serial tuning-control receiver.
package tune_pkg;

    localparam int TP_BAND_W = 4;
    localparam int TP_DIV_W  = 15;
    localparam int TP_TST_W  = 7;
    localparam int TP_PAD_W  = 8;

    // Legal frame lengths, derived from the field widths
    localparam int TP_LEN_STD   = TP_BAND_W + TP_DIV_W;
    localparam int TP_LEN_SHORT = TP_LEN_STD - 1;
    localparam int TP_LEN_LONG  = TP_LEN_STD + TP_TST_W + TP_PAD_W;

    // Positions inside the test field
    localparam int TP_REF_BIT   = 5;
    localparam int TP_ROUTE_BIT = 4;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_SHORT = 2'd1,
        FK_STD   = 2'd2,
        FK_LONG  = 2'd3
    } frame_kind_e;

endpackage

// File: rtl/tfr_edge.sv
// Module tfr_edge
// Detects qualified bit-clock rising edges and the falling edge of the
// frame enable. Assumes bus_clk and bus_en are already synchronous to clk.
module tfr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    input  logic bus_en,
    output logic shift_en,
    output logic en_fall
);

    logic clk_d;
    logic en_d;

    // Remember last sampled level of the serial clock and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_d <= 1'b0;
            en_d  <= 1'b0;
        end else begin
            clk_d <= bus_clk;
            en_d  <= bus_en;
        end
    end

    // Rising bit-clock edge counts only inside an active frame
    always_comb begin
        shift_en = bus_clk & ~clk_d & bus_en;
        en_fall  = en_d & ~bus_en;
    end

endmodule

// File: rtl/tfr_shift_count.sv
// Module tfr_shift_count
// Shift register (newest bit at index 0) and saturating bit counter.
// The counter is cleared while enable is low, so each frame starts at zero.
module tfr_shift_count #(
    parameter int SR_W  = 34,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_dat,
    input  logic             bus_en,
    input  logic             shift_en,
    output logic [SR_W-1:0]  sr_q,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SR_W + 1);

    // Shift in one data bit per qualified bit-clock edge, MSB-first framing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {sr_q[SR_W-2:0], bus_dat};
        end
    end

    // Count edges; saturate just beyond the longest frame so overlong is illegal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!bus_en) begin
            cnt_q <= '0;
        end else if (shift_en && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tfr_field_map.sv
// Module tfr_field_map
// Combinational mapping of the shift register into band, divider and test
// fields according to the counted frame length. Short and standard frames
// yield a zero test field; the short frame forces the top divider bit to 0.
module tfr_field_map
    import tune_pkg::*;
#(
    parameter int BAND_W = TP_BAND_W,
    parameter int DIV_W  = TP_DIV_W,
    parameter int TST_W  = TP_TST_W,
    parameter int PAD_W  = TP_PAD_W,
    parameter int CNT_W  = 6
) (
    input  logic [BAND_W+DIV_W+TST_W+PAD_W-1:0] sr,
    input  logic [CNT_W-1:0]                    cnt,
    output frame_kind_e                         kind,
    output logic [BAND_W-1:0]                   band,
    output logic [DIV_W-1:0]                    div,
    output logic [TST_W-1:0]                    test
);

    localparam int LEN_STD   = BAND_W + DIV_W;
    localparam int LEN_SHORT = LEN_STD - 1;
    localparam int LEN_LONG  = LEN_STD + TST_W + PAD_W;

    // Select layout by length; anything else is marked as no frame
    always_comb begin
        kind = FK_NONE;
        band = '0;
        div  = '0;
        test = '0;
        if (cnt == CNT_W'(LEN_LONG)) begin
            kind = FK_LONG;
            band = sr[LEN_LONG-1 -: BAND_W];
            div  = sr[LEN_LONG-BAND_W-1 -: DIV_W];
            test = sr[PAD_W+TST_W-1 -: TST_W];
        end else if (cnt == CNT_W'(LEN_STD)) begin
            kind = FK_STD;
            band = sr[LEN_STD-1 -: BAND_W];
            div  = sr[DIV_W-1:0];
        end else if (cnt == CNT_W'(LEN_SHORT)) begin
            kind = FK_SHORT;
            band = sr[LEN_SHORT-1 -: BAND_W];
            div  = {1'b0, sr[DIV_W-2:0]};
        end
    end

endmodule

// File: rtl/tune_frame_rx.sv
// Module tune_frame_rx
// Serial tuning-control frame receiver. Shifts data while enable is high,
// and on the enable fall loads band, divider and test registers if the
// frame length is 18, 19 or 34 bits; other lengths are dropped.
// Assumes the serial inputs are synchronous to clk.
module tune_frame_rx
    import tune_pkg::*;
#(
    parameter int BAND_W    = TP_BAND_W,
    parameter int DIV_W     = TP_DIV_W,
    parameter int TST_W     = TP_TST_W,
    parameter int PAD_W     = TP_PAD_W,
    parameter bit FIXED_REF = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_dat,
    input  logic              bus_clk,
    input  logic              bus_en,
    output logic [BAND_W-1:0] band_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [TST_W-1:0]  test_q,
    output logic              ref_div_1024,
    output logic              test_route,
    output logic              frame_taken
);

    localparam int SR_W  = BAND_W + DIV_W + TST_W + PAD_W;
    localparam int CNT_W = $clog2(SR_W + 2);

    logic              shift_en;
    logic              en_fall;
    logic [SR_W-1:0]   sr_q;
    logic [CNT_W-1:0]  cnt_q;
    frame_kind_e       kind;
    logic [BAND_W-1:0] band_n;
    logic [DIV_W-1:0]  div_n;
    logic [TST_W-1:0]  test_n;

    tfr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_clk  (bus_clk),
        .bus_en   (bus_en),
        .shift_en (shift_en),
        .en_fall  (en_fall)
    );

    tfr_shift_count #(
        .SR_W  (SR_W),
        .CNT_W (CNT_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_dat  (bus_dat),
        .bus_en   (bus_en),
        .shift_en (shift_en),
        .sr_q     (sr_q),
        .cnt_q    (cnt_q)
    );

    tfr_field_map #(
        .BAND_W (BAND_W),
        .DIV_W  (DIV_W),
        .TST_W  (TST_W),
        .PAD_W  (PAD_W),
        .CNT_W  (CNT_W)
    ) u_map (
        .sr   (sr_q),
        .cnt  (cnt_q),
        .kind (kind),
        .band (band_n),
        .div  (div_n),
        .test (test_n)
    );

    // Load the control registers at the end of a legal frame only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            band_q      <= '0;
            div_q       <= '0;
            test_q      <= '0;
            frame_taken <= 1'b0;
        end else begin
            frame_taken <= 1'b0;
            if (en_fall && (kind != FK_NONE)) begin
                band_q      <= band_n;
                div_q       <= div_n;
                test_q      <= test_n;
                frame_taken <= 1'b1;
            end
        end
    end

    // Reference ratio: programmable from the test field, or tied to 1024
    generate
        if (FIXED_REF) begin : g_ref_fixed
            assign ref_div_1024 = 1'b1;
        end else begin : g_ref_prog
            assign ref_div_1024 = test_q[TP_REF_BIT];
        end
    endgenerate

    // Test-frequency routing needs both upper band bits set
    assign test_route = test_q[TP_ROUTE_BIT] & band_q[BAND_W-1] & band_q[BAND_W-2];

endmodule

// File: rtl/tfr_checker.sv
// Module tfr_checker
// Property checker for tune_frame_rx. Keeps its own count of qualified
// bit-clock edges per frame to know the length of each loaded frame.
module tfr_checker
    import tune_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_clk,
    input logic                 bus_en,
    input logic [TP_BAND_W-1:0] band_q,
    input logic [TP_DIV_W-1:0]  div_q,
    input logic [TP_TST_W-1:0]  test_q,
    input logic                 test_route,
    input logic                 frame_taken
);

    logic       ck_clk_q;
    logic       ck_en_q;
    logic [5:0] ck_cnt;
    logic [5:0] ck_len;

    // Independent frame-length tracker from the bus pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_clk_q <= 1'b0;
            ck_en_q  <= 1'b0;
            ck_cnt   <= '0;
            ck_len   <= '0;
        end else begin
            ck_clk_q <= bus_clk;
            ck_en_q  <= bus_en;
            if (ck_en_q && !bus_en) ck_len <= ck_cnt;
            if (!bus_en) ck_cnt <= '0;
            else if (bus_clk && !ck_clk_q && ck_cnt != 6'd63) ck_cnt <= ck_cnt + 6'd1;
        end
    end

    p_strobe_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_taken |-> (!$past(bus_en) && $past(bus_en, 2)));

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_taken |=> !frame_taken);

    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_taken |-> ($stable(band_q) && $stable(div_q) && $stable(test_q)));

    p_legal_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_taken |-> (ck_len == 6'(TP_LEN_SHORT) || ck_len == 6'(TP_LEN_STD)
                         || ck_len == 6'(TP_LEN_LONG)));

    p_short_test_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_taken && ck_len != 6'(TP_LEN_LONG)) |-> (test_q == '0));

    p_short_top_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_taken && ck_len == 6'(TP_LEN_SHORT)) |-> !div_q[TP_DIV_W-1]);

    p_route_bands_r11: assert property (@(posedge clk) disable iff (!rst_n)
        test_route |-> (band_q[TP_BAND_W-1] && band_q[TP_BAND_W-2]));

endmodule

bind tune_frame_rx tfr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_clk     (bus_clk),
    .bus_en      (bus_en),
    .band_q      (band_q),
    .div_q       (div_q),
    .test_q      (test_q),
    .test_route  (test_route),
    .frame_taken (frame_taken)
);

// File: tb/tune_frame_rx_test.sv
// Scoreboard bench for tune_frame_rx: the driver pushes expected loads,
// the monitor pops them when frame_taken is seen.
module tune_frame_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_dat = 1'b0;
    logic        bus_clk = 1'b0;
    logic        bus_en = 1'b0;
    logic [3:0]  band_q;
    logic [14:0] div_q;
    logic [6:0]  test_q;
    logic        ref_div_1024;
    logic        test_route;
    logic        frame_taken;

    typedef struct packed {
        logic [3:0]  b;
        logic [14:0] n;
        logic [6:0]  t;
    } exp_t;

    exp_t q[$];
    exp_t mdl;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    tune_frame_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_dat      (bus_dat),
        .bus_clk      (bus_clk),
        .bus_en       (bus_en),
        .band_q       (band_q),
        .div_q        (div_q),
        .test_q       (test_q),
        .ref_div_1024 (ref_div_1024),
        .test_route   (test_route),
        .frame_taken  (frame_taken)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all outputs against one expected record
    task automatic cmp_all(input exp_t e, input string req);
        chk(band_q == e.b, req, "band_q", band_q, e.b);
        chk(div_q == e.n, req, "div_q", div_q, e.n);
        chk(test_q == e.t, req, "test_q", test_q, e.t);
        chk(ref_div_1024 == e.t[5], "R10", "ref_div_1024", ref_div_1024, e.t[5]);
        chk(test_route == (e.t[4] & e.b[3] & e.b[2]), "R11", "test_route",
            test_route, e.t[4] & e.b[3] & e.b[2]);
    endtask

    // Bench model of the field mapping, from the requirements
    function automatic bit decode(input int len, input logic [33:0] v, output exp_t e);
        e = '0;
        if (len == 34) begin
            e.b = v[33:30]; e.n = v[29:15]; e.t = v[14:8]; return 1'b1;
        end else if (len == 19) begin
            e.b = v[18:15]; e.n = v[14:0]; return 1'b1;
        end else if (len == 18) begin
            e.b = v[17:14]; e.n = {1'b0, v[13:0]}; return 1'b1;
        end
        return 1'b0;
    endfunction

    // Drive one frame of len bits, first bit is v[len-1]
    task automatic send_frame(input int len, input logic [33:0] v, input string req);
        exp_t e;
        bit   ok;
        @(negedge clk) bus_en = 1'b1;
        for (int i = len - 1; i >= 0; i--) begin
            @(negedge clk) begin bus_dat = v[i]; bus_clk = 1'b0; end
            @(negedge clk) bus_clk = 1'b1;
            @(negedge clk) bus_clk = 1'b0;
        end
        @(negedge clk);
        cmp_all(mdl, "R7");  // nothing moves while enable is high
        ok = decode(len, v, e);
        if (ok) begin
            q.push_back(e);
            mdl = e;
        end
        bus_en = 1'b0;
        repeat (3) @(negedge clk);
        if (!ok) cmp_all(mdl, req);  // illegal length keeps old contents
    endtask

    // Monitor: pop and compare on each load strobe
    always @(negedge clk) begin
        if (rst_n && frame_taken) begin
            if (q.size() == 0) begin
                chk(1'b0, "R6", "unexpected frame_taken", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                cmp_all(e, "R2/R3/R4");
            end
        end
    end

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        mdl = '0;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(band_q == 4'h0, "R1", "band_q", band_q, 0);
        chk(div_q == 15'h0, "R1", "div_q", div_q, 0);
        chk(test_q == 7'h0, "R1", "test_q", test_q, 0);
        chk(ref_div_1024 == 1'b0, "R1", "ref_div_1024", ref_div_1024, 0);
        chk(frame_taken == 1'b0, "R1", "frame_taken", frame_taken, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: standard frames
        send_frame(19, {15'h0, 4'b1010, 15'h2A5C}, "R2");
        send_frame(19, {15'h0, 4'b0101, 15'h7FFF}, "R2");
        // R3: short frame clears the top divider bit left set above
        send_frame(18, {16'h0, 4'b1111, 14'h3FFF}, "R3");
        send_frame(18, {16'h0, 4'b0011, 14'h0011}, "R3");
        // R4, R10, R11: long frame with T5 and T4 set and upper bands on
        send_frame(34, {4'b1100, 15'h1234, 7'b0110000, 8'hA5}, "R4");
        // R4: same fields, different padding
        send_frame(34, {4'b1100, 15'h1234, 7'b0110000, 8'h3C}, "R4");
        // R11: T4 set but band bit 3 clear
        send_frame(34, {4'b0100, 15'h0456, 7'b1011111, 8'hFF}, "R11");
        // R6: illegal lengths keep the last long-frame contents
        send_frame(33, {1'b0, 33'h1_2345_6789}, "R6");
        send_frame(20, 34'h0_000F_FFFF, "R6");
        send_frame(17, 34'h0_0001_5555, "R6");
        send_frame(35, 34'h3_FFFF_FFFF, "R6");
        send_frame(0, 34'h0, "R6");
        // R5: short frame after a long one returns test bits to zero
        send_frame(34, {4'b1100, 15'h7001, 7'b0110101, 8'h00}, "R4");
        send_frame(19, {15'h0, 4'b1100, 15'h0100}, "R5");
        chk(ref_div_1024 == 1'b0, "R5", "ref after std frame", ref_div_1024, 0);
        chk(test_route == 1'b0, "R5", "route after std frame", test_route, 0);
        // R8: bit-clock activity with enable low must not be counted
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) begin bus_clk = 1'b1; bus_dat = 1'b1; end
            @(negedge clk) bus_clk = 1'b0;
        end
        chk(frame_taken == 1'b0, "R8", "strobe while idle", frame_taken, 0);
        send_frame(18, {16'h0, 4'b0110, 14'h2AAA}, "R8");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule